// File: doc/BRIEF.md
# Sectioned Wave Memory Phase Oscillator Engine

This block is a time-multiplexed oscillator engine for a set of voice slots. By default there are 64 slots, and each one is serviced once per output sample period. Each slot owns a 24-bit phase accumulator. When a slot is serviced, the upper bits of its current phase select a word in a shared wave memory. The word read there is the slot's 14-bit output sample. The phase then advances by a frequency increment.

The increment is the sum of two terms. The first is a frequency word from an external ramp generator. The second is a modulation word taken from a shared interconnect register. Adding the second term lets the output of one slot linearly frequency-modulate another slot.

The wave memory is a single store, and a host loads it through its own write port, so any wave shape can be used. A per-slot control word splits the memory logically. A slot can read it as one full-size table, as one of two half-size tables, or as one of four quarter-size tables. Slots can mix these views, for example one half table beside two quarter tables. The host may rewrite one section while other slots read other sections.

The default memory depth is 4096 words to keep elaboration light. Setting `WAVE_AW` to 14 gives the full 16384-word store.

Top module: `wavetable_osc_engine`

## Requirements
- R1: Each time a slot is serviced with `run` high, that slot's phase becomes old phase + `ramp_freq` + `mod_word`, modulo 2^24. The phases of other slots are not changed.
- R2: `mod_word` is a two's-complement term added to the increment. With `ramp_freq` zero, the phase moves by `mod_word` alone, and negative values step it backwards.
- R3: When `slot_ctrl[3:2]` = 00 (full table), the memory address is the top `WAVE_AW` phase bits.
- R4: When `slot_ctrl[3:2]` = 01 (half table), the address MSB is `slot_ctrl[1]` and the remaining bits are the top `WAVE_AW`-1 phase bits. `slot_ctrl[0]` is ignored.
- R5: When `slot_ctrl[3:2]` is 10 or 11 (quarter table), the top two address bits are `slot_ctrl[1:0]` and the remaining bits are the top `WAVE_AW`-2 phase bits.
- R6: While `run` is low, serviced slots still produce samples, but no phase changes. Accumulation resumes from the held phase once `run` returns high.
- R7: One cycle after `slot_valid`, `sample_valid` is high, `sample_slot` equals the serviced index, and `sample` holds the word addressed by the phase before that service. `sample_valid` is low one cycle after any idle cycle.
- R8: A host write with `host_we` high stores `host_wdata` at `host_addr` in the same cycle as any oscillator read, and never stalls that read. A read of the same address in that cycle returns the previous contents.
- R9: After reset, all phases are zero and `sample_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Global accumulate enable; low freezes all phases |
| slot_valid | input | 1 | A slot is serviced this cycle |
| slot_idx | input | 6 | Index of the serviced slot |
| slot_ctrl | input | 4 | [3:2] table size, [1:0] section select |
| ramp_freq | input | 24 | Frequency term from the ramp generator |
| mod_word | input | 24 | Signed modulation term from an interconnect register |
| host_we | input | 1 | Wave memory write strobe |
| host_addr | input | 12 | Wave memory write address |
| host_wdata | input | 14 | Wave memory write data |
| sample_valid | output | 1 | Sample output is valid |
| sample_slot | output | 6 | Slot that produced the sample |
| sample | output | 14 | Wave memory word for that slot |

## Verification
The wave memory is preloaded with an injective function of the address, so every sample identifies exactly which word was read. One table of vectors drives slots through all three table sizes and every section code, including the size code 11 and the ignored low section bit. The vectors mix ramp-only, modulation-only, negative and wrapping increments, which separates a correct sum from a missing, sign-wrong or overflowing modulation term. Directed tests follow. They freeze the phases with `run`, read from a never-touched slot after reset, and collide a host write with a read of the same word, which shows read-before-write order and that the write took effect.

// File: rtl/osc_pkg.sv
package osc_pkg;

   typedef enum logic [1:0] {
      SZ_FULL  = 2'b00,
      SZ_HALF  = 2'b01,
      SZ_QUART = 2'b10,
      SZ_QALT  = 2'b11
   } tbl_size_e;

   typedef struct packed {
      tbl_size_e  size;
      logic [1:0] section;
   } osc_ctrl_t;

endpackage

// File: rtl/osc_phase_bank.sv
module osc_phase_bank #(
   parameter int NUM_SLOTS = 64,
   parameter int PHASE_W   = 24,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SLOT_W-1:0]  rd_idx,
   input  logic               upd_en,
   input  logic [PHASE_W-1:0] incr,
   output logic [PHASE_W-1:0] phase_cur
);

   logic [PHASE_W-1:0] phase_q [NUM_SLOTS];
   logic [PHASE_W-1:0] phase_nxt;

   assign phase_cur = phase_q[rd_idx];
   assign phase_nxt = phase_cur + incr;

   always_ff @(posedge clk) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (!rst_n)
            phase_q[i] <= '0;
         else if (upd_en && (rd_idx == SLOT_W'(i)))
            phase_q[i] <= phase_nxt;
      end
   end

endmodule

// File: rtl/osc_addr_map.sv
module osc_addr_map
   import osc_pkg::*;
#(
   parameter int PHASE_W = 24,
   parameter int WAVE_AW = 12
) (
   input  logic [PHASE_W-1:0] phase,
   input  osc_ctrl_t          ctrl,
   output logic [WAVE_AW-1:0] addr
);

   localparam int N_VARIANTS = 3;

   logic [N_VARIANTS-1:0][WAVE_AW-1:0] cand;

   for (genvar k = 0; k < N_VARIANTS; k++) begin : g_var
      if (k == 0) begin : g_full
         assign cand[k] = phase[PHASE_W-1 -: WAVE_AW];
      end else if (k == 1) begin : g_half
         assign cand[k] = {ctrl.section[1], phase[PHASE_W-1 -: WAVE_AW-1]};
      end else begin : g_quart
         assign cand[k] = {ctrl.section, phase[PHASE_W-1 -: WAVE_AW-2]};
      end
   end

   always_comb begin
      case (ctrl.size)
         SZ_FULL: addr = cand[0];
         SZ_HALF: addr = cand[1];
         default: addr = cand[2];
      endcase
   end

endmodule

// File: rtl/osc_wave_mem.sv
module osc_wave_mem #(
   parameter int WAVE_AW  = 12,
   parameter int SAMPLE_W = 14,
   localparam int DEPTH   = 1 << WAVE_AW
) (
   input  logic                clk,
   input  logic                we,
   input  logic [WAVE_AW-1:0]  waddr,
   input  logic [SAMPLE_W-1:0] wdata,
   input  logic [WAVE_AW-1:0]  raddr,
   output logic [SAMPLE_W-1:0] rdata
);

   logic [SAMPLE_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         store[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      rdata <= store[raddr];
   end

endmodule

// File: rtl/wavetable_osc_engine.sv
module wavetable_osc_engine
   import osc_pkg::*;
#(
   parameter int NUM_SLOTS = 64,
   parameter int PHASE_W   = 24,
   parameter int WAVE_AW   = 12,
   parameter int SAMPLE_W  = 14,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                slot_valid,
   input  logic [SLOT_W-1:0]   slot_idx,
   input  logic [3:0]          slot_ctrl,
   input  logic [PHASE_W-1:0]  ramp_freq,
   input  logic [PHASE_W-1:0]  mod_word,
   input  logic                host_we,
   input  logic [WAVE_AW-1:0]  host_addr,
   input  logic [SAMPLE_W-1:0] host_wdata,
   output logic                sample_valid,
   output logic [SLOT_W-1:0]   sample_slot,
   output logic [SAMPLE_W-1:0] sample
);

   if (WAVE_AW < 3 || WAVE_AW > PHASE_W) begin : g_bad_aw
      $error("WAVE_AW must lie between 3 and PHASE_W");
   end
   if (NUM_SLOTS < 2 || (1 << SLOT_W) != NUM_SLOTS) begin : g_bad_slots
      $error("NUM_SLOTS must be a power of two, at least 2");
   end

   osc_ctrl_t          ctrl_s;
   logic [PHASE_W-1:0] incr;
   logic [PHASE_W-1:0] phase_cur;
   logic [WAVE_AW-1:0] rd_addr;

   assign ctrl_s = osc_ctrl_t'(slot_ctrl);
   assign incr   = ramp_freq + mod_word;

   osc_phase_bank #(
      .NUM_SLOTS (NUM_SLOTS),
      .PHASE_W   (PHASE_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (slot_idx),
      .upd_en    (slot_valid && run),
      .incr      (incr),
      .phase_cur (phase_cur)
   );

   osc_addr_map #(
      .PHASE_W (PHASE_W),
      .WAVE_AW (WAVE_AW)
   ) u_map (
      .phase (phase_cur),
      .ctrl  (ctrl_s),
      .addr  (rd_addr)
   );

   osc_wave_mem #(
      .WAVE_AW  (WAVE_AW),
      .SAMPLE_W (SAMPLE_W)
   ) u_mem (
      .clk   (clk),
      .we    (host_we),
      .waddr (host_addr),
      .wdata (host_wdata),
      .raddr (rd_addr),
      .rdata (sample)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sample_valid <= 1'b0;
         sample_slot  <= '0;
      end else begin
         sample_valid <= slot_valid;
         if (slot_valid)
            sample_slot <= slot_idx;
      end
   end

endmodule

// File: rtl/osc_engine_chk.sv
module osc_engine_chk #(
   parameter int PHASE_W = 24,
   parameter int WAVE_AW = 12,
   parameter int SLOT_W  = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               slot_valid,
   input logic [SLOT_W-1:0]  slot_idx,
   input logic [3:0]         slot_ctrl,
   input logic [PHASE_W-1:0] phase_cur,
   input logic [WAVE_AW-1:0] rd_addr,
   input logic               sample_valid,
   input logic [SLOT_W-1:0]  sample_slot
);

   p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid |=> sample_valid);

   p_idle_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_valid |=> !sample_valid);

   p_slot_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid |=> (sample_slot == $past(slot_idx)));

   p_full_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid && slot_ctrl[3:2] == 2'b00)
         |-> (rd_addr == phase_cur[PHASE_W-1 -: WAVE_AW]));

   p_half_section_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid && slot_ctrl[3:2] == 2'b01)
         |-> (rd_addr[WAVE_AW-1] == slot_ctrl[1]));

   p_quarter_section_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid && slot_ctrl[3])
         |-> (rd_addr[WAVE_AW-1 -: 2] == slot_ctrl[1:0]));

endmodule

bind wavetable_osc_engine osc_engine_chk #(
   .PHASE_W (PHASE_W),
   .WAVE_AW (WAVE_AW),
   .SLOT_W  (SLOT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .slot_valid   (slot_valid),
   .slot_idx     (slot_idx),
   .slot_ctrl    (slot_ctrl),
   .phase_cur    (phase_cur),
   .rd_addr      (rd_addr),
   .sample_valid (sample_valid),
   .sample_slot  (sample_slot)
);

// File: tb/tb_wavetable_osc_engine.sv
module tb_wavetable_osc_engine;

   localparam int CLK_PERIOD = 10;
   localparam int N_VEC      = 12;
   localparam int DEPTH      = 4096;

   typedef struct packed {
      logic [5:0]  slot;
      logic [3:0]  ctrl;
      logic [23:0] ramp;
      logic [23:0] modw;
   } vec_t;

   localparam vec_t VECS [N_VEC] = '{
      '{6'd0,  4'b0000, 24'h123456, 24'h000000},
      '{6'd0,  4'b0000, 24'h123456, 24'h000000},
      '{6'd5,  4'b0110, 24'h0A0000, 24'h010000},
      '{6'd5,  4'b0101, 24'h0A0000, 24'h010000},
      '{6'd9,  4'b1011, 24'h7FFFFF, 24'h000001},
      '{6'd9,  4'b1101, 24'h7FFFFF, 24'h000001},
      '{6'd63, 4'b0000, 24'hF00000, 24'h200000},
      '{6'd63, 4'b0000, 24'hF00000, 24'h200000},
      '{6'd0,  4'b1000, 24'h000000, 24'hFFFFFF},
      '{6'd2,  4'b0000, 24'h000000, 24'h400000},
      '{6'd2,  4'b0000, 24'h000000, 24'h400000},
      '{6'd5,  4'b0111, 24'h000000, 24'h000000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b1;
   logic        slot_valid = 1'b0;
   logic [5:0]  slot_idx = '0;
   logic [3:0]  slot_ctrl = '0;
   logic [23:0] ramp_freq = '0;
   logic [23:0] mod_word = '0;
   logic        host_we = 1'b0;
   logic [11:0] host_addr = '0;
   logic [13:0] host_wdata = '0;
   logic        sample_valid;
   logic [5:0]  sample_slot;
   logic [13:0] sample;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [23:0] mdl_phase [64];
   logic [13:0] mdl_mem [DEPTH];

   always #(CLK_PERIOD/2) clk = ~clk;

   wavetable_osc_engine dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .slot_valid   (slot_valid),
      .slot_idx     (slot_idx),
      .slot_ctrl    (slot_ctrl),
      .ramp_freq    (ramp_freq),
      .mod_word     (mod_word),
      .host_we      (host_we),
      .host_addr    (host_addr),
      .host_wdata   (host_wdata),
      .sample_valid (sample_valid),
      .sample_slot  (sample_slot),
      .sample       (sample)
   );

   function automatic logic [13:0] wave_fn(int a);
      return 14'(a * 37 + 5);
   endfunction

   function automatic logic [11:0] exp_addr(logic [23:0] ph, logic [3:0] c);
      case (c[3:2])
         2'b00:   return ph[23:12];
         2'b01:   return {c[1], ph[23:13]};
         default: return {c[1:0], ph[23:14]};
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic service(logic [5:0] s, logic [3:0] c, logic [23:0] r,
                          logic [23:0] m, bit hw, logic [11:0] ha,
                          logic [13:0] hd, string tag);
      logic [13:0] ev;
      @(negedge clk);
      slot_valid = 1'b1;
      slot_idx   = s;
      slot_ctrl  = c;
      ramp_freq  = r;
      mod_word   = m;
      host_we    = hw;
      host_addr  = ha;
      host_wdata = hd;
      ev = mdl_mem[exp_addr(mdl_phase[s], c)];
      if (hw) mdl_mem[ha] = hd;
      if (run) mdl_phase[s] = mdl_phase[s] + r + m;
      @(negedge clk);
      slot_valid = 1'b0;
      host_we    = 1'b0;
      check({tag, " R7 valid"}, 32'(sample_valid), 32'd1);
      check({tag, " R7 slot"}, 32'(sample_slot), 32'(s));
      check({tag, " sample"}, 32'(sample), 32'(ev));
   endtask

   initial begin
      repeat (CLK_PERIOD * 15000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) mdl_phase[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: no sample after reset
      check("R9 reset valid", 32'(sample_valid), 32'd0);

      // R8: host preload through the write port
      for (int a = 0; a < DEPTH; a++) begin
         @(negedge clk);
         host_we    = 1'b1;
         host_addr  = 12'(a);
         host_wdata = wave_fn(a);
         mdl_mem[a] = wave_fn(a);
      end
      @(negedge clk);
      host_we = 1'b0;

      // R9: untouched slot reads phase zero
      service(6'd40, 4'b0000, 24'h0, 24'h0, 1'b0, '0, '0, "R9 zero phase");

      // R1 R2 R3 R4 R5: vector table across sizes, sections and increments
      for (int v = 0; v < N_VEC; v++) begin
         service(VECS[v].slot, VECS[v].ctrl, VECS[v].ramp, VECS[v].modw,
                 1'b0, '0, '0, $sformatf("R1 R2 R3 R4 R5 vec%0d", v));
      end

      // R6: freeze, samples still produced from held phase
      run = 1'b0;
      service(6'd63, 4'b0000, 24'h300000, 24'h0, 1'b0, '0, '0, "R6 frozen a");
      service(6'd63, 4'b0000, 24'h300000, 24'h0, 1'b0, '0, '0, "R6 frozen b");
      run = 1'b1;
      service(6'd63, 4'b0000, 24'h300000, 24'h0, 1'b0, '0, '0, "R6 resume a");
      service(6'd63, 4'b0000, 24'h300000, 24'h0, 1'b0, '0, '0, "R6 resume b");

      // R8: same-address collision returns old word, then the new one
      begin
         logic [11:0] ca;
         ca = exp_addr(mdl_phase[2], 4'b0000);
         service(6'd2, 4'b0000, 24'h0, 24'h0, 1'b1, ca, ~mdl_mem[ca], "R8 collide");
         service(6'd2, 4'b0000, 24'h0, 24'h0, 1'b0, '0, '0, "R8 after write");
      end

      // R7: idle cycle drops valid
      @(negedge clk);
      check("R7 idle", 32'(sample_valid), 32'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule